// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving end of a single-wire serial configuration link. When the three mode inputs are all zero, it takes the role of link master. First it holds an external serial memory in reset through an active-low init output. It then drives a configuration clock derived from the system clock and samples one data bit on each rising edge of that clock.

The incoming stream opens with a fixed sync pattern. A 24-bit length field follows, most significant bit first. The loader keeps clocking until that many further bits have arrived, then raises its done output. Done is meant to drive the memory's chip enable, so the source goes quiet once loading has finished. One configuration-clock period after done rises, the loader raises the user I/O enable.

A bad sync pattern or a zero length moves the loader to a sticky error state. A restart pulse aborts any phase and begins again with a fresh init phase.

Top module: `cfgLoader`

## Requirements
- R1: After reset, initN is low and cfgClk, cfgDone, ioEnable and cfgError are all low.
- R2: Loading starts only when modeSel equals 3'b000. With any other value the loader stays idle: initN stays low and cfgClk does not toggle, including after a restart.
- R3: Before each load, initN is held low for INIT_CYC system cycles, counted from the first clock edge that sees modeSel at zero. It is high for the whole time the clock runs.
- R4: While loading, cfgClk has a period of 2*DIV_HALF system cycles. serialIn is sampled on the system edge where cfgClk rises.
- R5: The first PRE_W sampled bits, the first one taken as the MSB, must equal PRE_PAT (default 8'hB2). Any other value ends the load in the error state after exactly PRE_W rising edges.
- R6: The next 24 bits, MSB first, form the body length N. N equal to zero ends the load in the error state after PRE_W+24 rising edges.
- R7: For N greater than zero, cfgClk rises exactly PRE_W+24+N times, and then cfgDone goes high.
- R8: Once cfgDone or cfgError is high, cfgClk stays low and makes no further rising edges.
- R9: ioEnable rises exactly 2*DIV_HALF system cycles after cfgDone rises.
- R10: In the error state, cfgError stays high and cfgDone stays low until a restart.
- R11: A restart pulse in any state drives initN low on the next cycle, clears the bit counters and reloads from the first bit of the stream.
- R12: bitLength shows the received N once the length field is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Mode select; 3'b000 selects master serial loading |
| restartReq | input | 1 | One-cycle pulse that aborts and restarts loading |
| serialIn | input | 1 | Serial configuration data from the memory |
| cfgClk | output | 1 | Generated configuration clock |
| initN | output | 1 | Active-low memory reset |
| cfgDone | output | 1 | High once all counted bits have been read; drives memory chip enable |
| ioEnable | output | 1 | User I/O enable, one clock period after done |
| cfgError | output | 1 | Sync mismatch or zero length detected |
| bitLength | output | 24 | Body length taken from the header |

## Verification
The embedded properties watch several rules on every cycle:
- the configuration clock falls silent when the control stops it, and a rising strobe always produces a high clock;
- an idle loader with a non-zero mode stays idle;
- a restart always lands in the init phase;
- done and error are never high together;
- the I/O enable only rises while done is already high.

Other behaviour only the bench scenarios can show, using a model memory whose address counter is reset by initN and frozen by done:
- exact rising-edge totals for good, bad-sync and zero-length streams;
- the init length;
- the clock period;
- the done-to-enable delay;
- that a mid-body restart really rewinds the memory, since otherwise the sync check would fail.

// File: rtl/cfgLoaderPkg.sv
package cfgLoaderPkg;

  localparam int CFG_LEN_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SYNC,
    ST_LEN,
    ST_BODY,
    ST_GRACE,
    ST_LIVE,
    ST_FAIL
  } loadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clkRun;
    logic clrField;
    logic loadLen;
    logic countBody;
    logic clrTimer;
  } pathCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic syncFull;
    logic syncOk;
    logic lenFull;
    logic lenZero;
    logic bodyLast;
    logic initHit;
    logic graceHit;
  } pathSts_t;

endpackage

// File: rtl/cfgLoaderPath.sv
module cfgLoaderPath
  import cfgLoaderPkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int INIT_CYC = 16,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_PAT = 8'hB2,
  parameter int LEN_W = CFG_LEN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  pathCtl_t         ctl,
  output pathSts_t         sts,
  output logic             cfgClk,
  output logic [LEN_W-1:0] bitLength
);

  localparam int DIV_W = $clog2(DIV_HALF + 1);
  localparam int FCNT_W = $clog2(LEN_W + 1);
  localparam int GRACE_CYC = 2 * DIV_HALF;
  localparam int TMAX = (INIT_CYC > GRACE_CYC) ? INIT_CYC : GRACE_CYC;
  localparam int TIMER_W = $clog2(TMAX + 1);

  logic [DIV_W-1:0]   divCnt;
  logic               cfgClkQ;
  logic               riseTick;
  logic [LEN_W-1:0]   hdrShift;
  logic [FCNT_W-1:0]  fieldCnt;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   lenCap;
  logic [TIMER_W-1:0] timer;

  // clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      cfgClkQ <= 1'b0;
    end else if (!ctl.clkRun) begin
      divCnt  <= '0;
      cfgClkQ <= 1'b0;
    end else if (divCnt == DIV_W'(DIV_HALF - 1)) begin
      divCnt  <= '0;
      cfgClkQ <= ~cfgClkQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign riseTick = ctl.clkRun && (divCnt == DIV_W'(DIV_HALF - 1)) && !cfgClkQ;
  assign cfgClk   = cfgClkQ;

  // header shifter and field counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrShift <= '0;
      fieldCnt <= '0;
    end else begin
      if (riseTick) hdrShift <= {hdrShift[LEN_W-2:0], serialIn};
      if (ctl.clrField) fieldCnt <= '0;
      else if (riseTick && fieldCnt != FCNT_W'(LEN_W)) fieldCnt <= fieldCnt + 1'b1;
    end
  end

  // body counter and captured length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      lenCap <= '0;
    end else if (ctl.loadLen) begin
      remain <= hdrShift;
      lenCap <= hdrShift;
    end else if (ctl.countBody && riseTick && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  // phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (ctl.clrTimer) timer <= '0;
    else if (timer != '1) timer <= timer + 1'b1;
  end

  assign sts.syncFull = (fieldCnt == FCNT_W'(PRE_W));
  assign sts.syncOk   = (hdrShift[PRE_W-1:0] == PRE_PAT);
  assign sts.lenFull  = (fieldCnt == FCNT_W'(LEN_W));
  assign sts.lenZero  = (hdrShift == '0);
  assign sts.bodyLast = (remain == '0);
  assign sts.initHit  = (timer == TIMER_W'(INIT_CYC - 1));
  assign sts.graceHit = (timer == TIMER_W'(GRACE_CYC - 1));
  assign bitLength    = lenCap;

  // R8
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clkRun |=> !cfgClk);

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |=> cfgClk);

endmodule

// File: rtl/cfgLoaderCtrl.sv
module cfgLoaderCtrl
  import cfgLoaderPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       restartReq,
  input  pathSts_t   sts,
  output pathCtl_t   ctl,
  output logic       initN,
  output logic       cfgDone,
  output logic       ioEnable,
  output logic       cfgError
);

  loadState_e state, nextState;
  logic       masterMode;

  assign masterMode = (modeSel == 3'b000);

  always_comb begin
    nextState = state;
    if (restartReq) begin
      nextState = ST_INIT;
    end else begin
      unique case (state)
        ST_IDLE:  if (masterMode) nextState = ST_INIT;
        ST_INIT:  if (sts.initHit) nextState = masterMode ? ST_SYNC : ST_IDLE;
        ST_SYNC:  if (sts.syncFull) nextState = sts.syncOk ? ST_LEN : ST_FAIL;
        ST_LEN:   if (sts.lenFull) nextState = sts.lenZero ? ST_FAIL : ST_BODY;
        ST_BODY:  if (sts.bodyLast) nextState = ST_GRACE;
        ST_GRACE: if (sts.graceHit) nextState = ST_LIVE;
        ST_LIVE:  nextState = ST_LIVE;
        ST_FAIL:  nextState = ST_FAIL;
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    ctl.clkRun    = (state == ST_SYNC) || (state == ST_LEN) || (state == ST_BODY);
    ctl.clrField  = (state != nextState) || restartReq;
    ctl.clrTimer  = (state != nextState) || restartReq;
    ctl.loadLen   = (state == ST_LEN) && sts.lenFull;
    ctl.countBody = (state == ST_BODY);
  end

  assign initN    = !((state == ST_IDLE) || (state == ST_INIT));
  assign cfgDone  = (state == ST_GRACE) || (state == ST_LIVE);
  assign ioEnable = (state == ST_LIVE);
  assign cfgError = (state == ST_FAIL);

  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !masterMode && !restartReq) |=> (state == ST_IDLE));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !initN);

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && cfgError));

  // R9
  io_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioEnable) |-> $past(cfgDone));

endmodule

// File: rtl/cfgLoader.sv
module cfgLoader
  import cfgLoaderPkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int INIT_CYC = 16,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PRE_PAT = 8'hB2,
  parameter int LEN_W = CFG_LEN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic             restartReq,
  input  logic             serialIn,
  output logic             cfgClk,
  output logic             initN,
  output logic             cfgDone,
  output logic             ioEnable,
  output logic             cfgError,
  output logic [LEN_W-1:0] bitLength
);

  pathCtl_t ctl;
  pathSts_t sts;

  cfgLoaderCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .restartReq (restartReq),
    .sts        (sts),
    .ctl        (ctl),
    .initN      (initN),
    .cfgDone    (cfgDone),
    .ioEnable   (ioEnable),
    .cfgError   (cfgError)
  );

  cfgLoaderPath #(
    .DIV_HALF (DIV_HALF),
    .INIT_CYC (INIT_CYC),
    .PRE_W    (PRE_W),
    .PRE_PAT  (PRE_PAT),
    .LEN_W    (LEN_W)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .ctl       (ctl),
    .sts       (sts),
    .cfgClk    (cfgClk),
    .bitLength (bitLength)
  );

endmodule

// File: tb/cfgLoader_tb_top.sv
module cfgLoader_tb_top;

  localparam int DIV_HALF = 2;
  localparam int INIT_CYC = 16;
  localparam logic [7:0] PRE_PAT = 8'hB2;
  localparam int MEM_D = 512;

  typedef struct {
    bit err;
    int rises;
    int len;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  modeSel;
  logic        restartReq;
  logic        serialIn;
  logic        cfgClk, initN, cfgDone, ioEnable, cfgError;
  logic [23:0] bitLength;

  logic memBits [0:MEM_D-1];
  int   memAddr = 0;
  int   riseCnt = 0;
  int   totalRises = 0;
  int   nChecks = 0;
  int   nFails = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  cfgLoader #(
    .DIV_HALF (DIV_HALF),
    .INIT_CYC (INIT_CYC),
    .PRE_W    (8),
    .PRE_PAT  (PRE_PAT)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .restartReq (restartReq),
    .serialIn   (serialIn),
    .cfgClk     (cfgClk),
    .initN      (initN),
    .cfgDone    (cfgDone),
    .ioEnable   (ioEnable),
    .cfgError   (cfgError),
    .bitLength  (bitLength)
  );

  // serial memory model: reset by initN, disabled by done
  always @(posedge cfgClk or negedge initN) begin
    if (!initN) memAddr <= 0;
    else if (!cfgDone && memAddr < MEM_D - 1) memAddr <= memAddr + 1;
  end
  assign serialIn = (initN && !cfgDone) ? memBits[memAddr] : 1'b1;

  always @(posedge cfgClk or negedge initN) begin
    if (!initN) riseCnt <= 0;
    else riseCnt <= riseCnt + 1;
  end
  always @(posedge cfgClk) totalRises <= totalRises + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic buildImage(input logic [7:0] pre, input logic [23:0] len, input int nBody);
    for (int i = 0; i < MEM_D; i++) memBits[i] = 1'b0;
    for (int i = 0; i < 8; i++) memBits[i] = pre[7-i];
    for (int i = 0; i < 24; i++) memBits[8+i] = len[23-i];
    for (int i = 0; i < nBody && 32 + i < MEM_D; i++) memBits[32+i] = (i % 3 == 0);
  endtask

  task automatic pushExp(input bit err, input int rises, input int len);
    expItem_t it;
    it.err = err;
    it.rises = rises;
    it.len = len;
    expQ.push_back(it);
  endtask

  task automatic pulseRestart();
    @(negedge clk) restartReq = 1'b1;
    @(negedge clk) restartReq = 1'b0;
  endtask

  task automatic waitDrained();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (expQ.size() == 0) break;
    end
    repeat (12) @(negedge clk);
  endtask

  // monitor: pop expected item on each completion
  initial begin
    forever begin
      @(posedge cfgDone or posedge cfgError);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected completion", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(cfgError == it.err, "R5/R6/R7 error flag", int'(cfgError), int'(it.err));
        check(riseCnt == it.rises, "R7 rising edge total", riseCnt, it.rises);
        if (!it.err) begin
          int c;
          check(bitLength == 24'(it.len), "R12 length", int'(bitLength), it.len);
          c = 0;
          for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (ioEnable) begin
              c = k;
              break;
            end
          end
          check(c == 2 * DIV_HALF, "R9 enable delay", c, 2 * DIV_HALF);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int snap;
    int lowCnt;
    realtime t0, t1;
    rstN = 1'b0;
    modeSel = 3'b111;
    restartReq = 1'b0;
    buildImage(PRE_PAT, 24'd5, 5);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(initN == 1'b0, "R1 initN", int'(initN), 0);
    check(cfgClk == 1'b0, "R1 cfgClk", int'(cfgClk), 0);
    check(cfgDone == 1'b0, "R1 cfgDone", int'(cfgDone), 0);
    check(ioEnable == 1'b0, "R1 ioEnable", int'(ioEnable), 0);
    check(cfgError == 1'b0, "R1 cfgError", int'(cfgError), 0);

    // R2: non-master mode stays idle
    modeSel = 3'b101;
    repeat (60) @(negedge clk);
    check(totalRises == 0, "R2 no clock in other mode", totalRises, 0);
    check(initN == 1'b0, "R2 initN held", int'(initN), 0);

    // good load, N=5
    pushExp(1'b0, 37, 5);
    modeSel = 3'b000;
    lowCnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (initN) break;
      lowCnt++;
    end
    check(lowCnt == INIT_CYC, "R3 init length", lowCnt, INIT_CYC);
    @(posedge cfgClk) t0 = $realtime;
    @(posedge cfgClk) t1 = $realtime;
    check(int'((t1 - t0) / 20.0) == 2 * DIV_HALF, "R4 clock period",
          int'((t1 - t0) / 20.0), 2 * DIV_HALF);
    waitDrained();
    snap = totalRises;
    repeat (40) @(negedge clk);
    check(totalRises == snap, "R8 clock stopped after done", totalRises, snap);
    check(cfgClk == 1'b0, "R8 cfgClk low", int'(cfgClk), 0);
    check(memAddr == 37, "R7 memory left at end", memAddr, 37);

    // bad sync pattern
    buildImage(8'hB3, 24'd5, 5);
    pushExp(1'b1, 8, 0);
    @(negedge clk) restartReq = 1'b1;
    @(negedge clk) restartReq = 1'b0;
    check(initN == 1'b0, "R11 initN after restart", int'(initN), 0);
    waitDrained();
    snap = totalRises;
    repeat (40) @(negedge clk);
    check(cfgError == 1'b1, "R10 error held", int'(cfgError), 1);
    check(cfgDone == 1'b0, "R10 done low", int'(cfgDone), 0);
    check(totalRises == snap, "R8 clock stopped after error", totalRises, snap);

    // zero length
    buildImage(PRE_PAT, 24'd0, 0);
    pushExp(1'b1, 32, 0);
    pulseRestart();
    waitDrained();
    check(bitLength == 24'd0, "R6 zero length shown", int'(bitLength), 0);

    // long body, N=200
    buildImage(PRE_PAT, 24'd200, 200);
    pushExp(1'b0, 232, 200);
    pulseRestart();
    waitDrained();

    // restart during body: memory must rewind
    buildImage(PRE_PAT, 24'd40, 40);
    pulseRestart();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (riseCnt >= 50) break;
    end
    check(cfgDone == 1'b0, "R11 mid-body not done", int'(cfgDone), 0);
    pushExp(1'b0, 72, 40);
    pulseRestart();
    waitDrained();

    // restart with non-master mode returns to idle
    modeSel = 3'b010;
    pulseRestart();
    repeat (60) @(negedge clk);
    snap = totalRises;
    repeat (20) @(negedge clk);
    check(totalRises == snap, "R2 idle after restart", totalRises, snap);
    check(initN == 1'b0, "R2 initN low in idle", int'(initN), 0);
    check(cfgDone == 1'b0, "R2 done low in idle", int'(cfgDone), 0);
    check(expQ.size() == 0, "R7 all results seen", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule